// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Cycle Controller

This block sits behind the bit-level front end of a serial EEPROM. The front end hands it whole bytes together with the chip-select level. The controller decodes each frame, serves array reads and status reads, and collects write data in a one-page buffer. When chip select is released after a valid write, it runs a self-timed busy period and commits the buffered bytes to the byte array. It also keeps the status register and enforces block and pin-based write protection.

The array is an internal register array of `2**ADDR_W` bytes. `ADDR_W = 14` gives the 16K-by-8 configuration. The default is 12 so that elaboration stays small. A page is `2**PAGE_W` bytes (64 by default). `BUSY_CYCLES` is the length of the write cycle in clocks. Set it to 5 ms times the clock rate; it must be at least one page long. Every data-phase byte slot of a read or status read is answered by one output byte one clock later. The front end shifts that byte out.

Top module: `eep_wr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and `rd_valid_o` stays low until a byte slot requests data.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, each as soon as the opcode byte is taken.
- R3: Opcode 0x03 is followed by an address high byte (its low `ADDR_W-8` bits are used) and a low byte. Each further byte slot returns the array byte at the current address one clock later. The address then increments and wraps from the last byte to address 0.
- R4: Opcode 0x02 is followed by two address bytes, and the data bytes after them go only to the page buffer. The write cycle starts on the clock that sees chip select high, and only if the frame carried at least one data byte.
- R5: The write offset wraps within the 64-byte page, so later bytes overwrite earlier ones at the same offset. Page bytes that the frame did not write keep their old contents.
- R6: A started write cycle shows busy (status bit 0 = 1) for exactly `BUSY_CYCLES` clocks. It then ends with busy 0 and the write-enable latch cleared.
- R7: If the write-enable latch is clear when chip select rises, a write or status-write frame has no effect and starts no busy period.
- R8: While busy, every opcode except 0x05 is ignored: write enable/disable, reads, writes and status writes change nothing and return no bytes.
- R9: The protection field encodes 00 = none, 01 = upper quarter, 10 = upper half, 11 = whole array. A write to a protected page is dropped with no busy period, and the write-enable latch stays set.
- R10: Opcode 0x01 followed by one byte starts a write cycle that loads status bit 7 (protection enable) and bits 3:2 (protection field). If `wp_ni` is low and protection enable is 1 when chip select rises, those bits keep their values.
- R11: The status byte reads {protect-enable, 3'b000, protection field, write-enable latch, busy}. Opcode 0x05 returns it on every byte slot that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select from the front end, active low |
| byte_valid_i | input | 1 | One-cycle strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect pin, active low |
| rd_valid_o | output | 1 | Response byte valid, one clock after the requesting byte slot |
| rd_data_o | output | 8 | Array or status byte to shift out |

## Verification
The assertions assume that the front end raises `byte_valid_i` only while chip select is low. They also assume that the busy length is at least one page, so the commit sweep ends before busy drops. They further assume that a frame's opcode is its first byte after chip select falls. The stimulus keeps to this by driving every byte inside a frame framed by chip-select edges on the falling clock edge. It leaves chip select high for at least one clock between frames. It only changes `wp_ni` between frames. Read-back compares are limited to addresses the bench has written, because the array is not reset.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_RDSR, OP_WRSR} op_e;
  typedef enum logic [2:0] {FS_OPC, FS_AHI, FS_ALO, FS_DATA, FS_STAT, FS_SREG, FS_SKIP} fstate_e;

  // msb2: two top address bits of the page, bp: protection field
  function automatic logic prot_hit(input logic [1:0] msb2, input logic [1:0] bp);
    case (bp)
      2'b01:   return &msb2;
      2'b10:   return msb2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eep_frame_fsm.sv
module eep_frame_fsm
  import eep_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              busy_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              buf_clr_o,
  output logic              rd_req_o,
  output logic              st_req_o,
  output logic              wr_byte_o,
  output logic [2:0]        sreg_o,
  output logic              sreg_vld_o
);
  fstate_e           st_q, st_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        sreg_q, sreg_d;
  logic              sv_q, sv_d;

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    addr_d    = addr_q;
    sreg_d    = sreg_q;
    sv_d      = sv_q;
    wel_set_o = 1'b0;
    wel_clr_o = 1'b0;
    buf_clr_o = 1'b0;
    rd_req_o  = 1'b0;
    st_req_o  = 1'b0;
    wr_byte_o = 1'b0;
    if (cs_n_i) begin
      st_d = FS_OPC;
      op_d = OP_NONE;
    end else if (byte_valid_i) begin
      case (st_q)
        FS_OPC: begin
          st_d = FS_SKIP;
          op_d = OP_NONE;
          if (!busy_i || byte_i == OPC_RDSR) begin
            case (byte_i)
              OPC_READ:  begin op_d = OP_READ;  st_d = FS_AHI; end
              OPC_WRITE: begin op_d = OP_WRITE; st_d = FS_AHI; buf_clr_o = 1'b1; end
              OPC_RDSR:  begin op_d = OP_RDSR;  st_d = FS_STAT; end
              OPC_WRSR:  begin op_d = OP_WRSR;  st_d = FS_SREG; sv_d = 1'b0; end
              OPC_WREN:  wel_set_o = 1'b1;
              OPC_WRDI:  wel_clr_o = 1'b1;
              default:   ;
            endcase
          end
        end
        FS_AHI: begin
          addr_d[ADDR_W-1:8] = byte_i[ADDR_W-9:0];
          st_d = FS_ALO;
        end
        FS_ALO: begin
          addr_d[7:0] = byte_i;
          st_d = FS_DATA;
        end
        FS_DATA: begin
          if (op_q == OP_READ) begin
            rd_req_o = 1'b1;
            addr_d   = ADDR_W'(addr_q + 1'b1);
          end else begin
            wr_byte_o = 1'b1;
            addr_d    = {addr_q[ADDR_W-1:PAGE_W], PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
          end
        end
        FS_STAT: st_req_o = 1'b1;
        FS_SREG: begin
          sreg_d = {byte_i[7], byte_i[3:2]};
          sv_d   = 1'b1;
          st_d   = FS_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_OPC;
      op_q   <= OP_NONE;
      addr_q <= '0;
      sreg_q <= '0;
      sv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      sreg_q <= sreg_d;
      sv_q   <= sv_d;
    end
  end

  assign op_o       = op_q;
  assign addr_o     = addr_q;
  assign sreg_o     = sreg_q;
  assign sreg_vld_o = sv_q;

  // R8: an opcode other than status read while busy leaves no live command
  a_r8_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !cs_n_i && st_q == FS_OPC && busy_i && byte_i != OPC_RDSR) |=> op_q == OP_NONE);

  // R5: data bytes of a write never leave the page
  a_r5_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_byte_o |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic [PAGE_W-1:0] rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_mask_o,
  output logic              any_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (wr_i)  mask_q[wr_off_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) data_q[wr_off_i] <= wr_data_i;
  end

  assign rd_data_o = data_q[rd_off_i];
  assign rd_mask_o = mask_q[rd_off_i];
  assign any_o     = |mask_q;

  // R4: a buffered byte always marks its slot
  a_r4_mark_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> mask_q[$past(wr_off_i)]);
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYCLES = 1250000,
  parameter int PAGE_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              sweep_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] SWEEP = CNT_W'(1 << PAGE_W);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = busy_q && cnt_q == LAST;
  assign sweep_o = busy_q && cnt_q < SWEEP;
  assign idx_o   = cnt_q[PAGE_W-1:0];

  // R6: a new cycle is never launched on top of a running one
  a_r6_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

  // R6: busy ends only through the terminal count
  a_r6_end_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/eep_wr_ctrl.sv
module eep_wr_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       wp_ni,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic              wel_set, wel_clr, buf_clr, rd_req, st_req, wr_byte;
  logic [2:0]        sreg;
  logic              sreg_vld;
  logic              busy, sweep, done;
  logic [PAGE_W-1:0] idx;
  logic [7:0]        buf_data;
  logic              buf_mask, buf_any;

  logic [7:0]        mem_q [DEPTH];
  logic              cs_n_q, wel_q, pen_q, kind_wr_q;
  logic [1:0]        bp_q;
  logic [PG_W-1:0]   page_q;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;

  eep_frame_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk_i, .rst_ni, .cs_n_i, .byte_valid_i, .byte_i,
    .busy_i(busy), .op_o(op), .addr_o(addr),
    .wel_set_o(wel_set), .wel_clr_o(wel_clr), .buf_clr_o(buf_clr),
    .rd_req_o(rd_req), .st_req_o(st_req), .wr_byte_o(wr_byte),
    .sreg_o(sreg), .sreg_vld_o(sreg_vld)
  );

  eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(wr_byte),
    .wr_off_i(addr[PAGE_W-1:0]), .wr_data_i(byte_i),
    .rd_off_i(idx), .rd_data_o(buf_data), .rd_mask_o(buf_mask), .any_o(buf_any)
  );

  eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy),
    .sweep_o(sweep), .idx_o(idx), .done_o(done)
  );

  logic cs_rise, lock, page_prot, commit_wr, commit_sr, start, mem_we;
  logic [7:0] status;

  assign cs_rise   = cs_n_i & ~cs_n_q;
  assign lock      = ~wp_ni & pen_q;
  assign page_prot = prot_hit(addr[ADDR_W-1 -: 2], bp_q);
  assign commit_wr = cs_rise && op == OP_WRITE && wel_q && buf_any && !page_prot;
  assign commit_sr = cs_rise && op == OP_WRSR && sreg_vld && wel_q;
  assign start     = commit_wr | commit_sr;
  assign status    = {pen_q, 3'b000, bp_q, wel_q, busy};
  assign mem_we    = sweep && kind_wr_q && buf_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q    <= 1'b1;
      wel_q     <= 1'b0;
      bp_q      <= 2'b00;
      pen_q     <= 1'b0;
      kind_wr_q <= 1'b0;
      page_q    <= '0;
    end else begin
      cs_n_q <= cs_n_i;
      if (wel_set) wel_q <= 1'b1;
      else if (wel_clr || done) wel_q <= 1'b0;
      if (commit_sr && !lock) begin
        pen_q <= sreg[2];
        bp_q  <= sreg[1:0];
      end
      if (start) begin
        kind_wr_q <= commit_wr;
        page_q    <= addr[ADDR_W-1:PAGE_W];
      end
    end
  end

  // commit sweep: one page slot per clock at the head of the busy period
  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[{page_q, idx}] <= buf_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req | st_req;
      if (st_req)      rd_data_q <= status;
      else if (rd_req) rd_data_q <= mem_q[addr];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R7: busy only ever follows a set write-enable latch
  a_r7_wel_before_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q));

  // R6: end of write cycle leaves the latch clear
  a_r6_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q);

  // R9: no array byte lands in a protected page
  a_r9_no_prot_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !prot_hit(page_q[PG_W-1 -: 2], bp_q));

  // R10: locked protection bits hold
  a_r10_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(~wp_ni & pen_q) |-> (bp_q == $past(bp_q)) && (pen_q == $past(pen_q)));

  // R8: no data byte is returned for a read while busy
  a_r8_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |-> !busy);
endmodule

// File: tb/eep_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module eep_wr_ctrl_tb_top;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int BC    = 100;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n = 1'b1;
  logic       bv = 1'b0;
  logic [7:0] bd = 8'h00;
  logic       wp_n = 1'b1;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;

  always #2 clk_i = ~clk_i;

  eep_wr_ctrl #(.ADDR_W(AW), .PAGE_W(6), .BUSY_CYCLES(BC)) dut_i (
    .clk_i, .rst_ni, .cs_n_i(cs_n), .byte_valid_i(bv), .byte_i(bd),
    .wp_ni(wp_n), .rd_valid_o, .rd_data_o
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [7:0] mm [DEPTH];
  bit         mk [DEPTH];
  logic [7:0] pb [64];
  bit         pm [64];
  int         m_busy, m_state, m_op, m_addr, c_page;
  bit         m_wel, m_pen, m_sv, m_csq, c_wr;
  bit [1:0]   m_bp;
  logic [7:0] m_sreg;
  bit         ev, ek;
  logic [7:0] ed;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_state = 0; m_op = 0; m_addr = 0; c_page = 0;
      m_wel = 0; m_pen = 0; m_sv = 0; m_csq = 1; c_wr = 0; m_bp = 0;
      m_sreg = 0; ev = 0; ek = 0; ed = 0;
      foreach (pm[i]) pm[i] = 0;
    end else begin
      automatic bit b = m_busy > 0;
      automatic logic [7:0] sb = {m_pen, 3'b000, m_bp, m_wel, b};
      ev = 0;
      if (!cs_n && bv) begin
        case (m_state)
          0: begin
            m_state = 6; m_op = 0;
            if (!b || bd == 8'h05) begin
              case (bd)
                8'h03: begin m_op = 1; m_state = 1; end
                8'h02: begin m_op = 2; m_state = 1; foreach (pm[i]) pm[i] = 0; end
                8'h05: begin m_op = 3; m_state = 4; end
                8'h01: begin m_op = 4; m_state = 5; m_sv = 0; end
                8'h06: m_wel = 1;
                8'h04: m_wel = 0;
                default: ;
              endcase
            end
          end
          1: begin m_addr = (int'(bd) % (DEPTH / 256)) * 256 + m_addr % 256; m_state = 2; end
          2: begin m_addr = m_addr - m_addr % 256 + int'(bd); m_state = 3; end
          3: begin
            if (m_op == 1) begin
              ev = 1; ed = mm[m_addr]; ek = mk[m_addr];
              m_addr = (m_addr + 1) % DEPTH;
            end else begin
              pb[m_addr % 64] = bd; pm[m_addr % 64] = 1;
              m_addr = m_addr - m_addr % 64 + (m_addr % 64 + 1) % 64;
            end
          end
          4: begin ev = 1; ed = sb; ek = 1; end
          5: begin m_sreg = bd; m_sv = 1; m_state = 6; end
          default: ;
        endcase
      end
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          if (c_wr)
            for (int i = 0; i < 64; i++)
              if (pm[i]) begin mm[c_page * 64 + i] = pb[i]; mk[c_page * 64 + i] = 1; end
          m_wel = 0;
        end
      end
      if (cs_n && !m_csq) begin
        automatic bit any = 0;
        automatic int top2 = m_addr / (DEPTH / 4);
        automatic bit prot = (m_bp == 1) ? top2 == 3 : (m_bp == 2) ? top2 >= 2 : (m_bp == 3);
        foreach (pm[i]) if (pm[i]) any = 1;
        if (m_op == 2 && m_wel && any && !prot) begin
          m_busy = BC; c_wr = 1; c_page = m_addr / 64;
        end else if (m_op == 4 && m_sv && m_wel) begin
          m_busy = BC; c_wr = 0;
          if (!(!wp_n && m_pen)) begin m_bp = m_sreg[3:2]; m_pen = m_sreg[7]; end
        end
      end
      if (cs_n) begin m_state = 0; m_op = 0; end
      m_csq = cs_n;
    end
  end

  // per-clock compare, away from the active edge
  always @(negedge clk_i) begin
    n_chk++;
    if (rd_valid_o !== ev) begin
      n_fail++;
      $display("FAIL %s: rd_valid act=%b exp=%b t=%0t", cur_req, rd_valid_o, ev, $time);
    end else if (ev && ek && rd_data_o !== ed) begin
      n_fail++;
      $display("FAIL %s: rd_data act=%h exp=%h t=%0t", cur_req, rd_data_o, ed, $time);
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk_i); bv = 1'b1; bd = b;
    @(negedge clk_i); bv = 1'b0;
  endtask
  task automatic cs_lo(); @(negedge clk_i); cs_n = 1'b0; endtask
  task automatic cs_hi(); @(negedge clk_i); cs_n = 1'b1; @(negedge clk_i); endtask
  task automatic cmd(input logic [7:0] op); cs_lo(); put(op); cs_hi(); endtask
  task automatic rdsr(); cs_lo(); put(8'h05); put(8'h00); cs_hi(); endtask
  task automatic wrsr(input logic [7:0] v); cs_lo(); put(8'h01); put(v); cs_hi(); endtask
  task automatic wr(input int a, input int n, input int seed);
    cs_lo(); put(8'h02); put(8'(a >> 8)); put(8'(a));
    for (int i = 0; i < n; i++) put(8'(seed + 3 * i));
    cs_hi();
  endtask
  task automatic rd(input int a, input int n);
    cs_lo(); put(8'h03); put(8'(a >> 8)); put(8'(a));
    for (int i = 0; i < n; i++) put(8'h00);
    cs_hi();
  endtask
  task automatic settle(); repeat (BC + 4) @(negedge clk_i); endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";  rdsr();                       // reset status 0x00
    cur_req = "R2";  cmd(8'h06); rdsr(); cmd(8'h04); rdsr();
    cur_req = "R7";  wr(16'h040, 4, 8'h11); rdsr(); rd(16'h040, 2);
    cur_req = "R4";  cmd(8'h06); wr(16'h010, 10, 8'h30); rdsr();
    cur_req = "R8";  cmd(8'h04); rd(16'h010, 3); wr(16'h200, 2, 8'h55); wrsr(8'h8C); rdsr();
    cur_req = "R6";  for (int i = 0; i < 16; i++) rdsr();
    settle(); rdsr();
    cur_req = "R4";  rd(16'h00E, 12);
    cur_req = "R5";  cmd(8'h06); wr(16'h080, 64, 8'h40); settle();
    cmd(8'h06); wr(16'h085, 3, 8'hA0); settle(); rd(16'h080, 64);
    cmd(8'h06); wr(16'h0FC, 70, 8'h10); settle(); rd(16'h0C0, 64);
    cur_req = "R3";  cmd(8'h06); wr(16'hFC0, 64, 8'h07); settle();
    cmd(8'h06); wr(16'h000, 8, 8'h90); settle();
    cmd(8'h06); wr(16'h800, 8, 8'h21); settle();
    cmd(8'h06); wr(16'hC00, 8, 8'h61); settle();
    rd(16'hFFE, 4);
    cur_req = "R10"; cmd(8'h06); wrsr(8'h84); rdsr(); settle(); rdsr();
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h00); settle(); rdsr();
    wp_n = 1'b1; cmd(8'h06); wrsr(8'h08); settle(); rdsr();
    cur_req = "R9";  cmd(8'h06); wr(16'h800, 4, 8'hEE); rdsr();
    wr(16'h400, 4, 8'h5A); settle(); rd(16'h800, 4); rd(16'h400, 4);
    cmd(8'h06); wrsr(8'h04); settle();
    cmd(8'h06); wr(16'hC00, 4, 8'hCC); rdsr(); wr(16'h800, 4, 8'h77); settle();
    rd(16'hC00, 4); rd(16'h800, 4);
    cmd(8'h06); wrsr(8'h0C); settle();
    cmd(8'h06); wr(16'h000, 4, 8'hDD); rdsr(); rd(16'h000, 4);
    cur_req = "R11"; cmd(8'h04); rdsr();
    repeat (4) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule